// File: doc/BRIEF.md
# Multiply-Accumulate Unit with HI/LO Accumulator

This block multiplies two 32-bit operands into a 64-bit product and folds that product into a 64-bit accumulator made of two 32-bit halves, HI (bits 63:32) and LO (bits 31:0). The product can be written straight into the accumulator, written as its two's-complement negation, added to the accumulator or taken away from it. A signedness flag picks sign extension or zero extension of both operands before the multiply. Each operation also returns one 32-bit word to the register port: the new LO, or the new HI when the high-half selector is set. Two counting operations return the number of leading one bits or leading zero bits of operand A and leave the accumulator alone.

The unit is a two-stage pipeline with a fixed latency. The first stage extends and multiplies, or counts. The second stage combines the result with the accumulator. Each stage is either empty or occupied. A stage moves from empty to occupied when work enters it and back to empty when no work follows. A start is accepted on every cycle. The accumulator is read and written only in the second stage, so a chain of back-to-back accumulate operations always sees the previous result without any forwarding. HI and LO are also visible on output ports.

Top module: `mac_hilo_unit`

## Requirements
- R1: A synchronous reset clears HI and LO to zero and holds done low.
- R2: With the signedness flag at 1, both operands are sign-extended to 64 bits before multiplying. With the flag at 0 they are zero-extended. The 64-bit product is taken modulo 2^64.
- R3: Opcode 0 (plain multiply) sets {HI,LO} to the product.
- R4: Opcode 1 (negated multiply) sets {HI,LO} to zero minus the product, modulo 2^64.
- R5: Opcode 2 (accumulate-add) sets {HI,LO} to its previous value plus the product, modulo 2^64.
- R6: Opcode 3 (accumulate-subtract) sets {HI,LO} to its previous value minus the product, modulo 2^64.
- R7: For opcodes 0, 1, 2, 3, 6 and 7, the result port carries the new HI when the high-half selector is 1 and the new LO when it is 0.
- R8: Opcode 5 returns the number of leading zero bits of operand A. An all-zero operand gives 32.
- R9: Opcode 4 returns the number of leading one bits of operand A. An all-ones operand gives 32.
- R10: Opcodes 4 and 5 leave HI and LO unchanged.
- R11: done is high for exactly one cycle, two clock edges after the edge that samples start. A start on every cycle is accepted. Each accumulate sees the accumulator left by the operation issued one cycle before it.
- R12: Opcodes 6 and 7 leave HI and LO unchanged and return the current half chosen by the selector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Issue an operation this cycle |
| op_i | input | 3 | Opcode (0 mul, 1 negated mul, 2 add, 3 subtract, 4 leading ones, 5 leading zeros, 6/7 read) |
| signed_i | input | 1 | 1: sign-extend operands, 0: zero-extend |
| hi_sel_i | input | 1 | 1: return HI, 0: return LO |
| opa_i | input | 32 | Operand A (also the count operand) |
| opb_i | input | 32 | Operand B |
| done_o | output | 1 | Result valid pulse |
| result_o | output | 32 | Word returned to the register port |
| hi_o | output | 32 | Accumulator bits 63:32 |
| lo_o | output | 32 | Accumulator bits 31:0 |

## Verification
A corrupted accumulator shows on hi_o and lo_o in the cycle after the faulty operation completes. Because every later accumulate builds on it, the error also persists into every following result until a plain or negated multiply overwrites it. A wrong extension or a lost sign in the product appears in the first signed run with a negative operand, usually in HI. A timing fault in the pipeline shows as done arriving on the wrong edge, or as a back-to-back accumulate chain whose totals drift from the bench's running sum within two cycles.

// File: rtl/mac_hilo_pkg.sv
package mac_hilo_pkg;

    typedef enum logic [2:0] {
        OP_MUL  = 3'd0,
        OP_NMUL = 3'd1,
        OP_MADD = 3'd2,
        OP_MSUB = 3'd3,
        OP_CLO  = 3'd4,
        OP_CLZ  = 3'd5,
        OP_RDA  = 3'd6,
        OP_RDB  = 3'd7
    } mac_op_e;

    typedef enum logic {
        STG_EMPTY = 1'b0,
        STG_BUSY  = 1'b1
    } stage_state_e;

endpackage

// File: rtl/mac_lead_count.sv
module mac_lead_count #(
    parameter int DW = 32,
    parameter int CW = $clog2(DW) + 1
) (
    input  logic [DW-1:0] val_i,
    input  logic          ones_i,
    output logic [CW-1:0] cnt_o
);

    logic [DW-1:0] scan;
    logic          hit;

    always_comb begin
        scan  = ones_i ? ~val_i : val_i;
        cnt_o = CW'(DW);
        hit   = 1'b0;
        for (int i = DW - 1; i >= 0; i--) begin
            if (!hit && scan[i]) begin
                cnt_o = CW'(DW - 1 - i);
                hit   = 1'b1;
            end
        end
    end

    // R8 / R9: a leading count never exceeds the operand width
    always_comb begin
        p_count_range_r8: assert (cnt_o <= CW'(DW));
    end

endmodule

// File: rtl/mac_mul_stage.sv
module mac_mul_stage
    import mac_hilo_pkg::*;
#(
    parameter int DW = 32,
    parameter int PW = 2 * DW,
    parameter int CW = $clog2(DW) + 1
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          start_i,
    input  mac_op_e       op_i,
    input  logic          signed_i,
    input  logic          hi_sel_i,
    input  logic [DW-1:0] opa_i,
    input  logic [DW-1:0] opb_i,
    output stage_state_e  st_o,
    output mac_op_e       op_o,
    output logic          hi_sel_o,
    output logic [PW-1:0] prod_o,
    output logic [CW-1:0] cnt_o
);

    logic [PW-1:0] ext_a;
    logic [PW-1:0] ext_b;
    logic [PW-1:0] prod_d;
    logic [CW-1:0] cnt_d;
    stage_state_e  st_d;

    always_comb begin
        ext_a  = signed_i ? {{DW{opa_i[DW-1]}}, opa_i} : {{DW{1'b0}}, opa_i};
        ext_b  = signed_i ? {{DW{opb_i[DW-1]}}, opb_i} : {{DW{1'b0}}, opb_i};
        prod_d = ext_a * ext_b;
    end

    mac_lead_count #(.DW(DW), .CW(CW)) u_count (
        .val_i  (opa_i),
        .ones_i (op_i == OP_CLO),
        .cnt_o  (cnt_d)
    );

    // stage transition: EMPTY -> BUSY on start, BUSY -> EMPTY without start
    always_comb begin
        unique case (st_o)
            STG_EMPTY: st_d = start_i ? STG_BUSY : STG_EMPTY;
            STG_BUSY:  st_d = start_i ? STG_BUSY : STG_EMPTY;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_o <= STG_EMPTY;
        end else begin
            st_o <= st_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            op_o     <= OP_MUL;
            hi_sel_o <= 1'b0;
            prod_o   <= '0;
            cnt_o    <= '0;
        end else if (start_i) begin
            op_o     <= op_i;
            hi_sel_o <= hi_sel_i;
            prod_o   <= prod_d;
            cnt_o    <= cnt_d;
        end
    end

endmodule

// File: rtl/mac_acc_stage.sv
module mac_acc_stage
    import mac_hilo_pkg::*;
#(
    parameter int DW = 32,
    parameter int PW = 2 * DW,
    parameter int CW = $clog2(DW) + 1
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  stage_state_e  st_i,
    input  mac_op_e       op_i,
    input  logic          hi_sel_i,
    input  logic [PW-1:0] prod_i,
    input  logic [CW-1:0] cnt_i,
    output logic          done_o,
    output logic [DW-1:0] result_o,
    output logic [PW-1:0] acc_o
);

    logic [PW-1:0] acc_d;
    logic [DW-1:0] res_d;
    logic          is_count;
    stage_state_e  st_q;

    always_comb begin
        is_count = 1'b0;
        unique case (op_i)
            OP_MUL:  acc_d = prod_i;
            OP_NMUL: acc_d = '0 - prod_i;
            OP_MADD: acc_d = acc_o + prod_i;
            OP_MSUB: acc_d = acc_o - prod_i;
            OP_CLO, OP_CLZ: begin
                acc_d    = acc_o;
                is_count = 1'b1;
            end
            OP_RDA, OP_RDB: acc_d = acc_o;
        endcase
        if (is_count) begin
            res_d = DW'(cnt_i);
        end else if (hi_sel_i) begin
            res_d = acc_d[PW-1:DW];
        end else begin
            res_d = acc_d[DW-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q     <= STG_EMPTY;
            acc_o    <= '0;
            result_o <= '0;
        end else begin
            st_q <= st_i;
            if (st_i == STG_BUSY) begin
                acc_o    <= acc_d;
                result_o <= res_d;
            end
        end
    end

    always_comb begin
        unique case (st_q)
            STG_EMPTY: done_o = 1'b0;
            STG_BUSY:  done_o = 1'b1;
        endcase
    end

    p_reset_clear_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (acc_o == '0) && !done_o);

    p_mul_load_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_i == STG_BUSY) && (op_i == OP_MUL) |=> acc_o == $past(prod_i));

    p_neg_load_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_i == STG_BUSY) && (op_i == OP_NMUL) |=> (acc_o + $past(prod_i)) == '0);

    p_acc_add_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_i == STG_BUSY) && (op_i == OP_MADD) |=> (acc_o - $past(acc_o)) == $past(prod_i));

    p_acc_sub_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_i == STG_BUSY) && (op_i == OP_MSUB) |=> ($past(acc_o) - acc_o) == $past(prod_i));

    p_count_keep_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_i == STG_BUSY) && ((op_i == OP_CLO) || (op_i == OP_CLZ)) |=> $stable(acc_o));

    p_read_keep_r12: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_i == STG_BUSY) && ((op_i == OP_RDA) || (op_i == OP_RDB)) |=> $stable(acc_o));

endmodule

// File: rtl/mac_hilo_unit.sv
module mac_hilo_unit
    import mac_hilo_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          start_i,
    input  logic [2:0]    op_i,
    input  logic          signed_i,
    input  logic          hi_sel_i,
    input  logic [DW-1:0] opa_i,
    input  logic [DW-1:0] opb_i,
    output logic          done_o,
    output logic [DW-1:0] result_o,
    output logic [DW-1:0] hi_o,
    output logic [DW-1:0] lo_o
);

    localparam int PW = 2 * DW;
    localparam int CW = $clog2(DW) + 1;

    stage_state_e  s1_st;
    mac_op_e       s1_op;
    logic          s1_hi_sel;
    logic [PW-1:0] s1_prod;
    logic [CW-1:0] s1_cnt;
    logic [PW-1:0] acc;

    mac_mul_stage #(.DW(DW), .PW(PW), .CW(CW)) u_mul (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .start_i  (start_i),
        .op_i     (mac_op_e'(op_i)),
        .signed_i (signed_i),
        .hi_sel_i (hi_sel_i),
        .opa_i    (opa_i),
        .opb_i    (opb_i),
        .st_o     (s1_st),
        .op_o     (s1_op),
        .hi_sel_o (s1_hi_sel),
        .prod_o   (s1_prod),
        .cnt_o    (s1_cnt)
    );

    mac_acc_stage #(.DW(DW), .PW(PW), .CW(CW)) u_acc (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .st_i     (s1_st),
        .op_i     (s1_op),
        .hi_sel_i (s1_hi_sel),
        .prod_i   (s1_prod),
        .cnt_i    (s1_cnt),
        .done_o   (done_o),
        .result_o (result_o),
        .acc_o    (acc)
    );

    assign hi_o = acc[PW-1:DW];
    assign lo_o = acc[DW-1:0];

    p_done_origin_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> $past(start_i, 2));

    p_done_latency_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(start_i, 2) && !$past(rst_i, 1) && !$past(rst_i, 2) |-> done_o);

    p_count_result_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i && (op_i == 3'd5) && (opa_i == '0) |=> ##1 (result_o == DW'(DW)));

endmodule

// File: tb/mac_hilo_unit_tb_top.sv
module mac_hilo_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  op;
    logic        sgn;
    logic        hsel;
    logic [31:0] opa;
    logic [31:0] opb;
    logic        done;
    logic [31:0] result;
    logic [31:0] hi;
    logic [31:0] lo;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    logic [63:0] m_acc = '0;

    logic        d1_done = 0, d2_done = 0;
    logic [31:0] d1_res = 0, d2_res = 0;
    logic [63:0] d1_acc = 0, d2_acc = 0;
    string       d1_tag = "R11", d2_tag = "R11";

    always #(CLK_PERIOD / 2) clk = ~clk;

    mac_hilo_unit dut_i (
        .clk_i    (clk),
        .rst_i    (rst),
        .start_i  (start),
        .op_i     (op),
        .signed_i (sgn),
        .hi_sel_i (hsel),
        .opa_i    (opa),
        .opb_i    (opb),
        .done_o   (done),
        .result_o (result),
        .hi_o     (hi),
        .lo_o     (lo)
    );

    function automatic logic [63:0] f_prod(logic [31:0] a, logic [31:0] b, logic s);
        logic [63:0] ea, eb;
        ea = s ? {{32{a[31]}}, a} : {32'd0, a};
        eb = s ? {{32{b[31]}}, b} : {32'd0, b};
        return ea * eb;
    endfunction

    function automatic logic [31:0] f_lead0(logic [31:0] v);
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) return 32'(31 - i);
        end
        return 32'd32;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic st, input logic [2:0] o, input logic s,
                        input logic h, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] p;
        logic [31:0] r;
        string       t;
        @(negedge clk);
        chk(done === d2_done, "R11", "done", 64'(done), 64'(d2_done));
        if (d2_done) chk(result === d2_res, d2_tag, "result", 64'(result), 64'(d2_res));
        chk({hi, lo} === d2_acc, d2_tag, "hi:lo", {hi, lo}, d2_acc);
        d2_done = d1_done; d2_res = d1_res; d2_acc = d1_acc; d2_tag = d1_tag;
        start = st; op = o; sgn = s; hsel = h; opa = a; opb = b;
        t = "R11";
        r = '0;
        if (st) begin
            p = f_prod(a, b, s);
            case (o)
                3'd0: begin m_acc = p;          t = "R3 R2 R7"; end
                3'd1: begin m_acc = 64'd0 - p;  t = "R4 R2 R7"; end
                3'd2: begin m_acc = m_acc + p;  t = "R5 R2 R7"; end
                3'd3: begin m_acc = m_acc - p;  t = "R6 R2 R7"; end
                3'd4: t = "R9 R10";
                3'd5: t = "R8 R10";
                default: t = "R12 R7";
            endcase
            if (o == 3'd4) r = f_lead0(~a);
            else if (o == 3'd5) r = f_lead0(a);
            else r = h ? m_acc[63:32] : m_acc[31:0];
        end
        d1_done = st; d1_res = r; d1_acc = m_acc; d1_tag = t;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!ended) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; start = 0; op = 0; sgn = 0; hsel = 0; opa = 0; opb = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk({hi, lo} === 64'd0, "R1", "hi:lo after reset", {hi, lo}, 64'd0);
        chk(done === 1'b0, "R1", "done after reset", 64'(done), 64'd0);

        // R8/R9 corners
        step(1, 3'd5, 0, 0, 32'h0000_0000, 0);
        step(1, 3'd4, 0, 0, 32'hFFFF_FFFF, 0);
        step(1, 3'd5, 0, 0, 32'h0000_0001, 0);
        step(1, 3'd4, 0, 0, 32'h7FFF_FFFF, 0);
        step(1, 3'd4, 0, 0, 32'hFFF0_0000, 0);
        step(1, 3'd5, 0, 0, 32'h8000_0000, 0);
        // R2/R3 extremes, both halves
        step(1, 3'd0, 1, 1, 32'h8000_0000, 32'h8000_0000);
        step(1, 3'd0, 1, 0, 32'hFFFF_FFFF, 32'h0000_0003);
        step(1, 3'd0, 0, 1, 32'hFFFF_FFFF, 32'h0000_0003);
        step(1, 3'd0, 0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        // R4 negated, signed and unsigned
        step(1, 3'd1, 0, 1, 32'h0000_0002, 32'h0000_0005);
        step(1, 3'd1, 1, 0, 32'hFFFF_FFFE, 32'h0000_0005);
        // R11 back-to-back accumulate chain, R5/R6
        step(1, 3'd0, 0, 0, 32'h0000_0000, 32'h0000_0000);
        step(1, 3'd2, 0, 0, 32'hFFFF_FFFF, 32'h0000_0010);
        step(1, 3'd2, 1, 1, 32'hFFFF_FFFF, 32'h0000_0010);
        step(1, 3'd3, 0, 1, 32'h1234_5678, 32'h9ABC_DEF0);
        step(1, 3'd3, 1, 0, 32'h8000_0000, 32'h7FFF_FFFF);
        // R10/R12: accumulator kept across counts and reads
        step(1, 3'd5, 0, 1, 32'h0001_0000, 0);
        step(1, 3'd6, 0, 1, 32'hDEAD_BEEF, 32'h1);
        step(1, 3'd7, 1, 0, 32'h1, 32'hDEAD_BEEF);
        step(0, 3'd0, 0, 0, 32'h5, 32'h5);
        step(1, 3'd0, 0, 0, 32'h0, 32'h0);
        step(1, 3'd3, 0, 1, 32'h0000_0001, 32'h0000_0001);

        for (int n = 0; n < 3000; n++) begin
            logic [31:0] a, b;
            int pick;
            pick = $urandom_range(0, 9);
            a = $urandom();
            b = $urandom();
            if (pick == 0) a = 32'h0;
            if (pick == 1) a = 32'hFFFF_FFFF;
            if (pick == 2) b = 32'h8000_0000;
            if (pick == 3) a = a >> $urandom_range(0, 31);
            step(($urandom_range(0, 4) != 0), 3'($urandom_range(0, 7)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, b);
        end
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);

        ended = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule